// File: doc/BRIEF.md
# Parallel 6x6 Matrix Multiplier

This block computes the product C = A x B of two square matrices of signed two's-complement integers. The default size is 6x6 with 36-bit elements. Before a run, software-side logic writes the operands through two write ports. Each row of A goes to a separate storage bank, and each column of B goes to a separate storage bank. Because of this split, every bank can supply one element per cycle.

A start strobe launches the computation. Six multiply-accumulate lanes then work on one result row at a time. Lane k forms C[i][k] from row i of A and column k of B. The rows are handled in order 0 to 5. When a row's sums are complete, they are pushed one per cycle into a small output FIFO. The FIFO presents the results on a valid/ready stream in row-major order.

A one-cycle done pulse follows the acceptance of the last result. After that pulse the block is idle and can be reloaded and started again.

Top module: `mm6_matmul`

## Requirements
- R1: After synchronous reset, `res_valid`, `done` and `busy` are all 0.
- R2: A write with `a_we` stores `a_data` as A[`a_row`][`a_col`]. A write with `b_we` stores `b_data` as B[`b_row`][`b_col`]. Each streamed result equals the exact signed dot product of the addressed row of A and column of B.
- R3: Results are `2*DW+clog2(DIM)` bits wide (75 by default), sign-extended, and never overflow. This holds even when every operand is the most negative 36-bit value, where each element is 6*2^70.
- R4: Exactly 36 results are delivered per start, in row-major order: C[0][0], C[0][1], and so on up to C[5][5].
- R5: While `res_valid` is 1 and `res_ready` is 0, `res_valid` stays 1 and `res_data` does not change on the next cycle. No result is lost or duplicated under any ready pattern.
- R6: `done` is high for exactly one cycle: the cycle after the 36th result is accepted. `busy` is 1 from the cycle after an accepted start until that same cycle.
- R7: A `start` pulse while `busy` is 1 has no effect. The current product completes unchanged, and no extra results follow `done`.
- R8: With `res_ready` held at 1, `done` rises no more than 400 clock cycles after the accepted start.
- R9: A new start after `done` computes a fresh product from the current bank contents. No sums carry over from the previous run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Starts a product when idle |
| a_we | input | 1 | Write enable for matrix A |
| a_row | input | 3 | Row index of the A element (selects bank) |
| a_col | input | 3 | Column index of the A element (address in bank) |
| a_data | input | 36 | Signed A element |
| b_we | input | 1 | Write enable for matrix B |
| b_row | input | 3 | Row index of the B element (address in bank) |
| b_col | input | 3 | Column index of the B element (selects bank) |
| b_data | input | 36 | Signed B element |
| busy | output | 1 | A product is in progress |
| done | output | 1 | One-cycle pulse after the last result is taken |
| res_valid | output | 1 | FIFO head holds a result |
| res_ready | input | 1 | Consumer accepts the head result |
| res_data | output | 75 | Signed result element |

## Verification
The FIFO can be written by the drain of a finished row and popped by the consumer in the same cycle. When it is full, the drain must stall while the accumulators keep their sums. The bench provokes this by toggling `res_ready` pseudo-randomly, so pushes, pops, full stalls and simultaneous push/pop all occur in one run. It judges the outcome by scoreboard order and values, and by checking that a stalled head word stays the same. A second coincidence is a new `start` arriving mid-run while results are draining. The bench checks that the result sequence stays intact and that the block is quiet after `done`.

// File: rtl/mm6_pkg.sv
package mm6_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_FLUSH,
        ST_DRAIN,
        ST_FINISH
    } mm_state_e;

    // Operand pipeline tag carried alongside the data in each lane
    typedef struct packed {
        logic vld;
        logic first;
    } lane_tag_t;

    // Number of register stages between issue and accumulator update, minus one
    localparam int MM_PIPE_FLUSH = 2;

    function automatic int acc_width(input int dw, input int dim);
        return 2 * dw + $clog2(dim);
    endfunction

endpackage

// File: rtl/mm6_bank.sv
module mm6_bank #(
    parameter int DEPTH = 6,
    parameter int DW    = 36,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    logic [DW-1:0] store [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH))
            store[waddr] <= wdata;
    end

    always_comb begin
        rdata = '0;
        if (int'(raddr) < DEPTH)
            rdata = store[raddr];
    end
endmodule

// File: rtl/mm6_lane.sv
module mm6_lane
    import mm6_pkg::*;
#(
    parameter int DW   = 36,
    parameter int ACCW = 75
) (
    input  logic                   clk,
    input  logic                   rst,
    input  lane_tag_t              tag_in,
    input  logic signed [DW-1:0]   op_a,
    input  logic signed [DW-1:0]   op_b,
    output logic signed [ACCW-1:0] acc
);
    localparam int PW = 2 * DW;

    lane_tag_t               tag1, tag2;
    logic signed [DW-1:0]    a_q, b_q;
    logic signed [PW-1:0]    prod;
    logic signed [ACCW-1:0]  prod_ext;

    assign prod_ext = {{(ACCW-PW){prod[PW-1]}}, prod};

    always_ff @(posedge clk) begin
        if (rst) begin
            tag1 <= '0;
            tag2 <= '0;
            a_q  <= '0;
            b_q  <= '0;
            prod <= '0;
            acc  <= '0;
        end else begin
            tag1 <= tag_in;
            a_q  <= op_a;
            b_q  <= op_b;
            tag2 <= tag1;
            prod <= a_q * b_q;
            if (tag2.vld)
                acc <= tag2.first ? prod_ext : acc + prod_ext;
        end
    end
endmodule

// File: rtl/mm6_fifo.sv
module mm6_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 75,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] din,
    output logic         full,
    input  logic         ready,
    output logic         valid,
    output logic [W-1:0] dout,
    output logic         pop
);
    logic [W-1:0]  slots [DEPTH];
    logic [AW-1:0] wp, rp;
    logic [CW-1:0] cnt;
    logic          do_push;

    assign valid   = (cnt != '0);
    assign full    = (cnt == CW'(DEPTH));
    assign pop     = valid && ready;
    assign do_push = push && !full;
    assign dout    = slots[rp];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push)
            slots[wp] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp  <= '0;
            rp  <= '0;
            cnt <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (pop)     rp <= bump(rp);
            case ({do_push, pop})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    // R5: occupancy never exceeds the storage
    a_r5_no_overflow: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R5: a stalled head word is held
    a_r5_stall_hold: assert property (@(posedge clk) disable iff (rst)
        (valid && !ready) |=> (valid && $stable(dout)));
endmodule

// File: rtl/mm6_ctrl.sv
module mm6_ctrl
    import mm6_pkg::*;
#(
    parameter int DIM   = 6,
    localparam int IDXW = $clog2(DIM),
    localparam int TOT  = DIM * DIM,
    localparam int CW   = $clog2(TOT + 1),
    localparam int FW   = $clog2(MM_PIPE_FLUSH + 1)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            fifo_full,
    input  logic            pop,
    output lane_tag_t       issue_tag,
    output logic [IDXW-1:0] issue_idx,
    output logic [IDXW-1:0] row_idx,
    output logic            push,
    output logic [IDXW-1:0] drain_sel,
    output logic            busy,
    output logic            done
);
    localparam logic [IDXW-1:0] LAST = IDXW'(DIM - 1);

    mm_state_e       st;
    logic [IDXW-1:0] kcnt, row, dcnt;
    logic [FW-1:0]   fcnt;
    logic [CW-1:0]   taken;

    assign issue_tag.vld   = (st == ST_ISSUE);
    assign issue_tag.first = (kcnt == '0);
    assign issue_idx       = kcnt;
    assign row_idx         = row;
    assign push            = (st == ST_DRAIN) && !fifo_full;
    assign drain_sel       = dcnt;
    assign busy            = (st != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= ST_IDLE;
            kcnt  <= '0;
            row   <= '0;
            dcnt  <= '0;
            fcnt  <= '0;
            taken <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (st)
                ST_IDLE: begin
                    if (start) begin
                        st    <= ST_ISSUE;
                        kcnt  <= '0;
                        row   <= '0;
                        taken <= '0;
                    end
                end
                ST_ISSUE: begin
                    if (kcnt == LAST) begin
                        st   <= ST_FLUSH;
                        fcnt <= '0;
                    end else begin
                        kcnt <= kcnt + 1'b1;
                    end
                end
                ST_FLUSH: begin
                    if (fcnt == FW'(MM_PIPE_FLUSH - 1)) begin
                        st   <= ST_DRAIN;
                        dcnt <= '0;
                    end else begin
                        fcnt <= fcnt + 1'b1;
                    end
                end
                ST_DRAIN: begin
                    if (!fifo_full) begin
                        if (dcnt == LAST) begin
                            kcnt <= '0;
                            if (row == LAST) begin
                                st <= ST_FINISH;
                            end else begin
                                row <= row + 1'b1;
                                st  <= ST_ISSUE;
                            end
                        end else begin
                            dcnt <= dcnt + 1'b1;
                        end
                    end
                end
                default: ;
            endcase
            if ((st != ST_IDLE) && pop) begin
                taken <= taken + 1'b1;
                if (taken == CW'(TOT - 1)) begin
                    done <= 1'b1;
                    st   <= ST_IDLE;
                end
            end
        end
    end

    // R6: completion is a single-cycle pulse
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R6: completion only follows an accepted result
    a_r6_done_after_pop: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(pop));

    // R7: activity only begins from a start request
    a_r7_busy_from_start: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(start));
endmodule

// File: rtl/mm6_matmul.sv
module mm6_matmul
    import mm6_pkg::*;
#(
    parameter int DIM        = 6,
    parameter int DW         = 36,
    parameter int FIFO_DEPTH = 4,
    localparam int IDXW      = $clog2(DIM),
    localparam int ACCW      = acc_width(DW, DIM)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            a_we,
    input  logic [IDXW-1:0] a_row,
    input  logic [IDXW-1:0] a_col,
    input  logic [DW-1:0]   a_data,
    input  logic            b_we,
    input  logic [IDXW-1:0] b_row,
    input  logic [IDXW-1:0] b_col,
    input  logic [DW-1:0]   b_data,
    output logic            busy,
    output logic            done,
    output logic            res_valid,
    input  logic            res_ready,
    output logic [ACCW-1:0] res_data
);
    lane_tag_t        issue_tag;
    logic [IDXW-1:0]  issue_idx, row_idx, drain_sel;
    logic             push, fifo_full, pop;
    logic [DW-1:0]    a_rd [DIM];
    logic [DW-1:0]    b_rd [DIM];
    logic [ACCW-1:0]  lane_acc [DIM];
    logic [DW-1:0]    a_sel;

    assign a_sel = a_rd[row_idx];

    for (genvar g = 0; g < DIM; g++) begin : g_col
        logic signed [ACCW-1:0] acc_s;

        mm6_bank #(.DEPTH(DIM), .DW(DW)) u_a_bank (
            .clk   (clk),
            .we    (a_we && (a_row == IDXW'(g))),
            .waddr (a_col),
            .wdata (a_data),
            .raddr (issue_idx),
            .rdata (a_rd[g])
        );

        mm6_bank #(.DEPTH(DIM), .DW(DW)) u_b_bank (
            .clk   (clk),
            .we    (b_we && (b_col == IDXW'(g))),
            .waddr (b_row),
            .wdata (b_data),
            .raddr (issue_idx),
            .rdata (b_rd[g])
        );

        mm6_lane #(.DW(DW), .ACCW(ACCW)) u_lane (
            .clk    (clk),
            .rst    (rst),
            .tag_in (issue_tag),
            .op_a   (a_sel),
            .op_b   (b_rd[g]),
            .acc    (acc_s)
        );

        assign lane_acc[g] = acc_s;
    end

    mm6_ctrl #(.DIM(DIM)) u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .start     (start),
        .fifo_full (fifo_full),
        .pop       (pop),
        .issue_tag (issue_tag),
        .issue_idx (issue_idx),
        .row_idx   (row_idx),
        .push      (push),
        .drain_sel (drain_sel),
        .busy      (busy),
        .done      (done)
    );

    mm6_fifo #(.DEPTH(FIFO_DEPTH), .W(ACCW)) u_fifo (
        .clk   (clk),
        .rst   (rst),
        .push  (push),
        .din   (lane_acc[drain_sel]),
        .full  (fifo_full),
        .ready (res_ready),
        .valid (res_valid),
        .dout  (res_data),
        .pop   (pop)
    );
endmodule

// File: tb/mm6_matmul_tb.sv
module mm6_matmul_tb;
    localparam int DIM  = 6;
    localparam int DW   = 36;
    localparam int ACCW = 2 * DW + $clog2(DIM);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic a_we = 1'b0, b_we = 1'b0;
    logic [2:0] a_row = '0, a_col = '0, b_row = '0, b_col = '0;
    logic [DW-1:0] a_data = '0, b_data = '0;
    logic busy, done, res_valid, res_ready;
    logic [ACCW-1:0] res_data;

    int checks = 0, fails = 0;
    int cyc = 0;
    int rdy_mode = 0;
    int done_events = 0;
    bit last_taken = 1'b0;
    bit prev_stall = 1'b0;
    logic [ACCW-1:0] prev_data;
    logic signed [ACCW-1:0] exp_q [$];
    logic signed [DW-1:0] am [DIM][DIM];
    logic signed [DW-1:0] bm [DIM][DIM];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    mm6_matmul u_dut (
        .clk(clk), .rst(rst), .start(start),
        .a_we(a_we), .a_row(a_row), .a_col(a_col), .a_data(a_data),
        .b_we(b_we), .b_row(b_row), .b_col(b_col), .b_data(b_data),
        .busy(busy), .done(done),
        .res_valid(res_valid), .res_ready(res_ready), .res_data(res_data)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [ACCW-1:0] act, input logic [ACCW-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Monitor / scoreboard: drives ready, checks stalls, results and done
    always @(negedge clk) begin
        if (rst) begin
            res_ready = 1'b0;
            prev_stall = 1'b0;
        end else begin
            if (prev_stall)
                check(res_valid && (res_data == prev_data), "R5", "stalled head changed",
                      res_data, prev_data);
            if (last_taken) begin
                check(done === 1'b1, "R6", "done after last result", ACCW'(done), 1);
                last_taken = 1'b0;
                if (done) done_events++;
            end else if (done) begin
                check(1'b0, "R6", "done at wrong cycle", 1, 0);
            end
            res_ready = (rdy_mode == 0) ? 1'b1 : (($urandom % 3) != 0);
            if (res_valid && res_ready) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R4", "extra result", res_data, 0);
                end else begin
                    logic signed [ACCW-1:0] e;
                    e = exp_q.pop_front();
                    check(res_data == e, "R2", "result value/order (R4)", res_data, e);
                    if (exp_q.size() == 0) last_taken = 1'b1;
                end
            end
            prev_stall = res_valid && !res_ready;
            prev_data  = res_data;
        end
    end

    task automatic load_and_expect();
        for (int i = 0; i < DIM; i++) begin
            for (int j = 0; j < DIM; j++) begin
                a_we = 1'b1; a_row = 3'(i); a_col = 3'(j); a_data = am[i][j];
                b_we = 1'b1; b_row = 3'(i); b_col = 3'(j); b_data = bm[i][j];
                @(negedge clk);
            end
        end
        a_we = 1'b0; b_we = 1'b0;
        for (int i = 0; i < DIM; i++) begin
            for (int k = 0; k < DIM; k++) begin
                logic signed [ACCW-1:0] s, ta, tb;
                s = '0;
                for (int j = 0; j < DIM; j++) begin
                    ta = am[i][j];
                    tb = bm[j][k];
                    s += ta * tb;
                end
                exp_q.push_back(s);
            end
        end
    endtask

    task automatic run(input int mode, input bit poke_start, input bit timed);
        int t0, target;
        rdy_mode = mode;
        load_and_expect();
        target = done_events + 1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t0 = cyc;
        check(busy === 1'b1, "R6", "busy after start", ACCW'(busy), 1);
        if (poke_start) begin
            repeat (25) @(negedge clk);
            start = 1'b1;          // R7: must be ignored
            @(negedge clk);
            start = 1'b0;
        end
        while (done_events < target) @(negedge clk);
        if (timed)
            check((cyc - t0) <= 400, "R8", "cycles to done", ACCW'(cyc - t0), 400);
        check(busy === 1'b0, "R6", "busy cleared with done", ACCW'(busy), 0);
        repeat (20) @(negedge clk);
        check(!res_valid && !busy && exp_q.size() == 0, "R7", "quiet after done",
              ACCW'(res_valid), 0);
    endtask

    function automatic logic signed [DW-1:0] rnd();
        return DW'({$urandom, $urandom});
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1
        check(!res_valid && !done && !busy, "R1", "reset state",
              ACCW'({res_valid, done, busy}), 0);

        // R2/R4/R8: random operands, free-flowing output
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                am[i][j] = rnd(); bm[i][j] = rnd();
            end
        run(0, 1'b0, 1'b1);

        // R3: extreme negative operands, plus max positive mix
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                am[i][j] = {1'b1, {(DW-1){1'b0}}};
                bm[i][j] = (i == 5 && j == 5) ? {1'b0, {(DW-1){1'b1}}}
                                             : {1'b1, {(DW-1){1'b0}}};
            end
        run(0, 1'b0, 1'b1);

        // R5/R7: random backpressure and a start during the run
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                am[i][j] = rnd(); bm[i][j] = rnd();
            end
        run(1, 1'b1, 1'b0);

        // R9: fresh product after done, identity times random
        for (int i = 0; i < DIM; i++)
            for (int j = 0; j < DIM; j++) begin
                am[i][j] = (i == j) ? DW'(1) : '0;
                bm[i][j] = rnd();
            end
        run(1, 1'b0, 1'b0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule